// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a behavioural model of a synchronous pipelined static memory, 32 bits wide, with a shared data bus. The bus is shown as two ports: a write-data input and a read-data output. A drive flag marks the cycles in which the read data would be driven onto the shared wires. An access begins when one of two address strobes is recognised on a rising clock edge. The processor strobe is recognised only while the first chip select is low, and it wins over the controller strobe. A two-bit burst counter then steps the low address bits on every edge where advance is low. It follows a linear or an interleaved order, chosen by a static mode input.

Writes behave differently for the two strobes. On the processor strobe's edge the write controls are ignored, and the write happens on the following edge. The controller strobe writes on its own edge. A global write stores all four byte lanes. Otherwise a byte-write enable qualifies one active-low select per lane. A read address is registered on one edge, and the word appears on the next edge. The output-enable input gates the drive flag without any clock delay. The default address width is reduced for elaboration, and setting the parameter to 15 gives the full 32K-word array.

Top module: `burst_sram_ctrl`

## Requirements
- R1: When a strobe is recognised with all three chip selects active (cs1_n low, cs2 high, cs3_n low) and both gwr_n and bwr_n high, the addressed word appears on rdata after the next rising edge. drive_en is high in that cycle when oe_n is low and that next edge is not a write or a deselect.
- R2: gwr_n low on a write edge stores all four byte lanes, whatever bwr_n and lane_n are.
- R3: With gwr_n high, lane i (data bits 8i+7 down to 8i; lane_n bit 0 covers bits 7:0 and bit 3 covers bits 31:24) is stored only when bwr_n is low and lane_n[i] is low. Other lanes keep their contents. With bwr_n high no lane is stored.
- R4: On the edge where the processor strobe is recognised, gwr_n, bwr_n, lane_n and adv_n are ignored. The write, if any, takes place on the next edge at the captured address, with the controls and wdata present at that edge.
- R5: A controller strobe with the processor strobe not recognised writes on that same edge when the write controls are active.
- R6: After any edge that performs a write, drive_en is low for the following cycle, whatever oe_n is.
- R7: In the first cycle after an access starts from the deselected state, drive_en is low.
- R8: After an edge with a recognised strobe and inactive chip selects, drive_en is low. Later edges without a strobe start no access.
- R9: Each edge with adv_n low during an active burst moves to the next beat. With burst_linear high, the low two address bits are (start + k) mod 4. With it low, they are start XOR k. The upper bits stay fixed.
- R10: An edge without a strobe and with adv_n high repeats the current address.
- R11: oe_n high forces drive_en low at once, without waiting for a clock edge.
- R12: During and after reset, drive_en is low, rdata is zero and no burst is active.
- R13: A read of an address after a write to it returns the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address sampled with a strobe |
| pstrobe_n | input | 1 | Processor address strobe, active low |
| cstrobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select one, active low, also qualifies pstrobe_n |
| cs2 | input | 1 | Chip select two, active high |
| cs3_n | input | 1 | Chip select three, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_n | input | DATA_W/8 | Per-lane byte selects, active low |
| burst_linear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, combinational |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| drive_en | output | 1 | High when rdata would drive the shared bus |

## Verification
Global writes with mixed lane selects are compared against byte writes with sparse lane patterns. This separates the override path from the per-lane qualification. Processor-strobe writes carry junk controls on the first edge and real controls on the second, which shows which edge stores the data. Bursts that start at offsets 2 and 1 in the two orders separate linear wrap from XOR stepping. Suspend, deselect and write-after-read sequences, together with a long seeded random mix of strobes, selects and write controls, check the drive flag rules against a cycle model of the requirements.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
// Shared types and the burst order function for the pipelined SRAM model.
// Assumes a two-bit burst counter (four beats per burst).
package burst_sram_pkg;
    localparam int BURST_W = 2;

    typedef logic [BURST_W-1:0] beat_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    // Low address bits of beat 'step' of a burst that starts at 'start'.
    function automatic beat_t beat_offset(input beat_t start, input beat_t step,
                                          input logic linear);
        return linear ? beat_t'(start + step) : (start ^ step);
    endfunction
endpackage

// File: rtl/burst_addr_unit.sv
`timescale 1ns/1ps
// Burst address unit: holds the captured start address and beat counter,
// and presents the address used on the current edge.
// Assumes load and advance are never high together (the top gates them).
module burst_addr_unit
    import burst_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          linear,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] eff_addr
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] base_nx;
    beat_t         step_q;
    beat_t         step_nx;

    // Pick the start address and beat that apply to this edge.
    always_comb begin
        base_nx = load ? addr_in : base_q;
        if (load) begin
            step_nx = '0;
        end else if (advance) begin
            step_nx = step_q + 1'b1;
        end else begin
            step_nx = step_q;
        end
    end

    assign eff_addr = {base_nx[AW-1:BURST_W],
                       beat_offset(base_nx[BURST_W-1:0], step_nx, linear)};

    // Keep the burst start and beat for the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            step_q <= '0;
        end else begin
            base_q <= base_nx;
            step_q <= step_nx;
        end
    end
endmodule

// File: rtl/byte_write_decode.sv
`timescale 1ns/1ps
// Byte-write decoder: turns global write, byte-write enable and the
// active-low lane selects into a per-lane write mask.
// Assumes lane i covers data bits [8i+7:8i].
module byte_write_decode #(
    parameter int LANES = 4
) (
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // A lane is stored on global write, or on a qualified byte select.
        assign lane_mask[g] = ~gwr_n | (~bwr_n & ~lane_n[g]);
    end
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
// Behavioural memory array with a per-lane write mask and a combinational
// read port. Assumes DW is a multiple of 8 and the contents are not reset.
module sram_array #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [DW/8-1:0]   lane_mask,
    input  logic [AW-1:0]     waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DW-1:0]     rd_word
);
    localparam int DEPTH = 1 << AW;
    localparam int LANES = DW / 8;

    logic [DW-1:0] mem [DEPTH];

    // Store the selected lanes of the write word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_mask[i]) begin
                    mem[waddr][8*i +: 8] <= wdata[8*i +: 8];
                end
            end
        end
    end

    assign rd_word = mem[raddr];
endmodule

// File: rtl/output_stage.sv
`timescale 1ns/1ps
// Output register stage: captures the array word one edge after a read was
// addressed, and holds the drive flag that output enable then gates.
// Assumes 'kill' is high on write and deselect edges.
module output_stage #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_pend,
    input  logic          kill,
    input  logic [DW-1:0] arr_word,
    input  logic          oe_n,
    output logic [DW-1:0] rdata,
    output logic          drive_en
);
    logic          drv_q;
    logic [DW-1:0] data_q;

    // Register read data and the drive flag for the cycle after the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q  <= 1'b0;
            data_q <= '0;
        end else begin
            drv_q <= rd_pend & ~kill;
            if (rd_pend) begin
                data_q <= arr_word;
            end
        end
    end

    assign rdata    = data_q;
    assign drive_en = drv_q & ~oe_n;
endmodule

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
// Pipelined burst SRAM access controller with its behavioural array.
// Decodes the two strobes and chip selects on each edge. It sequences one-edge
// writes (controller strobe) and second-edge writes (processor strobe),
// steps bursts, and drives registered read data one edge after the address.
// Assumes burst_linear is held static and the shared bus is split into
// wdata/rdata with drive_en marking the driven cycles.
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                pstrobe_n,
    input  logic                cstrobe_n,
    input  logic                adv_n,
    input  logic                cs1_n,
    input  logic                cs2,
    input  logic                cs3_n,
    input  logic                gwr_n,
    input  logic                bwr_n,
    input  logic [DATA_W/8-1:0] lane_n,
    input  logic                burst_linear,
    input  logic                oe_n,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                drive_en
);
    localparam int LANES = DATA_W / 8;

    logic              chip_sel;
    logic              p_hit;
    logic              c_hit;
    logic              strobe_hit;
    logic              new_acc;
    logic              desel;
    logic              cont;
    logic              proc_first;
    logic              wr_ok;
    logic              wr_now;
    logic              active_q;
    logic              rd_pend_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [ADDR_W-1:0] eff_addr;
    logic [LANES-1:0]  lane_mask;
    logic [DATA_W-1:0] arr_word;
    acc_kind_t         acc_kind;

    // Classify this edge: new access, deselect, burst continuation or idle.
    always_comb begin
        chip_sel   = ~cs1_n & cs2 & ~cs3_n;
        p_hit      = ~pstrobe_n & ~cs1_n;
        c_hit      = ~cstrobe_n & ~p_hit;
        strobe_hit = p_hit | c_hit;
        new_acc    = strobe_hit & chip_sel;
        desel      = strobe_hit & ~chip_sel;
        cont       = active_q & ~strobe_hit;
        proc_first = p_hit & chip_sel;
        wr_ok      = (new_acc & ~proc_first) | cont;
        wr_now     = wr_ok & (|lane_mask);
        if (wr_now) begin
            acc_kind = ACC_WRITE;
        end else if (new_acc | cont) begin
            acc_kind = ACC_READ;
        end else begin
            acc_kind = ACC_IDLE;
        end
    end

    // Track whether a burst is open and which read, if any, is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            rd_pend_q <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            if (new_acc) begin
                active_q <= 1'b1;
            end else if (desel) begin
                active_q <= 1'b0;
            end
            rd_pend_q <= (acc_kind == ACC_READ);
            rd_addr_q <= eff_addr;
        end
    end

    burst_addr_unit #(.AW(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (new_acc),
        .advance  (cont & ~adv_n),
        .linear   (burst_linear),
        .addr_in  (addr),
        .eff_addr (eff_addr)
    );

    byte_write_decode #(.LANES(LANES)) u_bw (
        .gwr_n     (gwr_n),
        .bwr_n     (bwr_n),
        .lane_n    (lane_n),
        .lane_mask (lane_mask)
    );

    sram_array #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk       (clk),
        .wr_en     (acc_kind == ACC_WRITE),
        .lane_mask (lane_mask),
        .waddr     (eff_addr),
        .wdata     (wdata),
        .raddr     (rd_addr_q),
        .rd_word   (arr_word)
    );

    output_stage #(.DW(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pend  (rd_pend_q),
        .kill     (desel | wr_now),
        .arr_word (arr_word),
        .oe_n     (oe_n),
        .rdata    (rdata),
        .drive_en (drive_en)
    );
endmodule

// File: rtl/burst_sram_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for burst_sram_ctrl, attached with bind below.
// Assumes it sees the top's edge classification and burst address.
module burst_sram_ctrl_chk
    import burst_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          oe_n,
    input logic          adv_n,
    input logic          drive_en,
    input logic          wr_now,
    input logic          desel,
    input logic          new_acc,
    input logic          active_q,
    input logic          cont,
    input logic          proc_first,
    input logic [AW-1:0] eff_addr
);
    a_r11_oe_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive_en);

    a_r6_write_stops_drive: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |=> !drive_en);

    a_r8_deselect_stops_drive: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> !drive_en);

    a_r7_first_cycle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (new_acc && !active_q) |=> !drive_en);

    a_r4_no_first_edge_write: assert property (@(posedge clk) disable iff (!rst_n)
        proc_first |-> !wr_now);

    a_r9_upper_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        cont |-> eff_addr[AW-1:BURST_W] == $past(eff_addr[AW-1:BURST_W]));

    a_r10_suspend_repeats: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && adv_n) |-> eff_addr == $past(eff_addr));
endmodule

bind burst_sram_ctrl burst_sram_ctrl_chk #(.AW(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oe_n       (oe_n),
    .adv_n      (adv_n),
    .drive_en   (drive_en),
    .wr_now     (wr_now),
    .desel      (desel),
    .new_acc    (new_acc),
    .active_q   (active_q),
    .cont       (cont),
    .proc_first (proc_first),
    .eff_addr   (eff_addr)
);

// File: tb/tb_burst_sram_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared each cycle against a cycle model built from the requirements.
module tb_burst_sram_ctrl;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int LN = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          pstrobe_n, cstrobe_n, adv_n, cs1_n, cs2, cs3_n;
    logic          gwr_n, bwr_n, burst_linear, oe_n;
    logic [LN-1:0] lane_n;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          drive_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    burst_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .pstrobe_n(pstrobe_n),
        .cstrobe_n(cstrobe_n), .adv_n(adv_n), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n),
        .burst_linear(burst_linear), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .drive_en(drive_en)
    );

    // Cycle model state
    logic [DW-1:0] mm [1 << AW];
    bit            m_active = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_step = '0;
    bit            m_rdp = 1'b0;
    logic [AW-1:0] m_rda = '0;
    bit            m_drv = 1'b0;
    logic [DW-1:0] m_rdata = '0;
    string         m_tag = "R12";

    function automatic logic [DW-1:0] pat(input int a);
        return 32'h9E3779B9 * 32'(a + 1);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Advance the model by one rising edge using the inputs now applied.
    task automatic model_edge();
        bit sel, ph, chh, sh, nw, ds, ct, wr;
        logic [LN-1:0] msk;
        logic [AW-1:0] bs, ea;
        logic [1:0] st, lo;
        sel = !cs1_n && cs2 && !cs3_n;
        ph  = !pstrobe_n && !cs1_n;
        chh = !cstrobe_n && !ph;
        sh  = ph || chh;
        nw  = sh && sel;
        ds  = sh && !sel;
        ct  = m_active && !sh;
        for (int i = 0; i < LN; i++) msk[i] = !gwr_n || (!bwr_n && !lane_n[i]);
        wr  = ((chh && sel) || ct) && (msk != '0);
        bs  = nw ? addr : m_base;
        st  = nw ? 2'd0 : ((ct && !adv_n) ? 2'(m_step + 2'd1) : m_step);
        lo  = burst_linear ? 2'(bs[1:0] + st) : (bs[1:0] ^ st);
        ea  = {bs[AW-1:2], lo};
        if (m_rdp) m_rdata = mm[m_rda];
        m_drv = m_rdp && !(ds || wr);
        m_tag = wr ? "R6" : (ds ? "R8" : "R1");
        if (wr) begin
            for (int i = 0; i < LN; i++) if (msk[i]) mm[ea][8*i +: 8] = wdata[8*i +: 8];
        end
        m_rdp = (nw || ct) && !wr;
        m_rda = ea;
        if (nw) m_active = 1'b1;
        else if (ds) m_active = 1'b0;
        m_base = bs;
        m_step = st;
    endtask

    task automatic compare();
        check(m_tag, 32'(drive_en), 32'(m_drv && !oe_n));
        check("R1", rdata, m_rdata);
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        pstrobe_n = 1'b1; cstrobe_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; bwr_n = 1'b1; lane_n = '1; wdata = '0;
    endtask

    task automatic c_acc(input int a, input logic g, input logic b,
                         input logic [LN-1:0] ln, input logic [DW-1:0] d);
        cstrobe_n = 1'b0; addr = AW'(a); gwr_n = g; bwr_n = b; lane_n = ln; wdata = d;
        step();
        idle();
    endtask

    task automatic nxt(input logic adv, input logic g, input logic b,
                       input logic [LN-1:0] ln, input logic [DW-1:0] d);
        adv_n = adv; gwr_n = g; bwr_n = b; lane_n = ln; wdata = d;
        step();
        idle();
    endtask

    task automatic rd_check(input int a, input logic [DW-1:0] exp, input string tag);
        c_acc(a, 1'b1, 1'b1, '1, '0);
        nxt(1'b1, 1'b1, 1'b1, '1, '0);
        check(tag, rdata, exp);
        check(tag, 32'(drive_en), 32'd1);
    endtask

    initial begin
        #700000;
        n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; addr = '0; cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        oe_n = 1'b0; burst_linear = 1'b1;
        idle();
        repeat (3) @(negedge clk);
        check("R12", 32'(drive_en), 32'd0);
        check("R12", rdata, '0);
        rst_n = 1'b1;

        // Fill the array through controller-strobe global writes
        for (int a = 0; a < (1 << AW); a++) c_acc(a, 1'b0, 1'b1, '1, pat(a));

        // R2: global write overrides byte controls
        c_acc(5, 1'b0, 1'b1, 4'hF, 32'h11223344);
        rd_check(5, 32'h11223344, "R2");
        c_acc(6, 1'b0, 1'b0, 4'b1110, 32'hCAFEF00D);
        rd_check(6, 32'hCAFEF00D, "R2");

        // R3: lanes 0 and 2 only; then bwr_n high stores nothing
        c_acc(7, 1'b1, 1'b0, 4'b1010, 32'hAABBCCDD);
        rd_check(7, (pat(7) & 32'hFF00FF00) | 32'h00BB00DD, "R3");
        c_acc(8, 1'b1, 1'b1, 4'h0, 32'h12345678);
        rd_check(8, pat(8), "R3");

        // R5 and R13: same-edge write, read back at once
        c_acc(9, 1'b0, 1'b1, '1, 32'h0F0F1234);
        rd_check(9, 32'h0F0F1234, "R5");
        c_acc(10, 1'b1, 1'b0, 4'b0000, 32'h76543210);
        rd_check(10, 32'h76543210, "R13");

        // R4: processor strobe ignores junk controls and adv on first edge
        pstrobe_n = 1'b0; addr = AW'(12); gwr_n = 1'b0; bwr_n = 1'b0; lane_n = '0;
        adv_n = 1'b0; wdata = 32'hDEAD0000;
        step();
        idle();
        nxt(1'b1, 1'b0, 1'b1, '1, 32'h0BADCAFE);
        check("R4", 32'(drive_en), 32'd0);
        rd_check(12, 32'h0BADCAFE, "R4");
        rd_check(13, pat(13), "R4");

        // R6: write right after a read suppresses drive despite oe_n low
        c_acc(20, 1'b1, 1'b1, '1, '0);
        nxt(1'b1, 1'b0, 1'b1, '1, 32'h00000055);
        check("R6", 32'(drive_en), 32'd0);
        rd_check(20, 32'h00000055, "R13");

        // R8: deselect after a read, then idle edges start nothing
        c_acc(25, 1'b1, 1'b1, '1, '0);
        cs2 = 1'b0; cstrobe_n = 1'b0;
        step();
        cs2 = 1'b1; idle();
        check("R8", 32'(drive_en), 32'd0);
        step();
        check("R8", 32'(drive_en), 32'd0);
        check("R8", rdata, pat(25));

        // R7: first cycle out of deselect is quiet, then data drives
        c_acc(30, 1'b1, 1'b1, '1, '0);
        check("R7", 32'(drive_en), 32'd0);
        nxt(1'b1, 1'b1, 1'b1, '1, '0);
        check("R7", 32'(drive_en), 32'd1);
        check("R7", rdata, pat(30));

        // R9: linear burst from offset 2 wraps 2,3,0,1
        burst_linear = 1'b1;
        c_acc(34, 1'b1, 1'b1, '1, '0);
        nxt(1'b0, 1'b1, 1'b1, '1, '0); check("R9", rdata, pat(34));
        nxt(1'b0, 1'b1, 1'b1, '1, '0); check("R9", rdata, pat(35));
        nxt(1'b0, 1'b1, 1'b1, '1, '0); check("R9", rdata, pat(32));
        nxt(1'b1, 1'b1, 1'b1, '1, '0); check("R9", rdata, pat(33));

        // R9: interleaved burst from offset 1 steps 1,0,3,2
        burst_linear = 1'b0;
        c_acc(41, 1'b1, 1'b1, '1, '0);
        nxt(1'b0, 1'b1, 1'b1, '1, '0); check("R9", rdata, pat(41));
        nxt(1'b0, 1'b1, 1'b1, '1, '0); check("R9", rdata, pat(40));
        nxt(1'b0, 1'b1, 1'b1, '1, '0); check("R9", rdata, pat(43));
        nxt(1'b1, 1'b1, 1'b1, '1, '0); check("R9", rdata, pat(42));

        // R10: suspend repeats the address, advance then moves on
        c_acc(50, 1'b1, 1'b1, '1, '0);
        nxt(1'b1, 1'b1, 1'b1, '1, '0); check("R10", rdata, pat(50));
        nxt(1'b1, 1'b1, 1'b1, '1, '0); check("R10", rdata, pat(50));
        nxt(1'b0, 1'b1, 1'b1, '1, '0); check("R10", rdata, pat(50));
        nxt(1'b1, 1'b1, 1'b1, '1, '0); check("R10", rdata, pat(51));

        // R11: output enable gates drive between edges
        check("R11", 32'(drive_en), 32'd1);
        oe_n = 1'b1; #0.5;
        check("R11", 32'(drive_en), 32'd0);
        oe_n = 1'b0; #0.5;
        check("R11", 32'(drive_en), 32'd1);

        // Seeded random traffic against the cycle model
        for (int n = 0; n < 3000; n++) begin
            if (n % 500 == 0) burst_linear = 1'($urandom_range(0, 1));
            pstrobe_n = ($urandom_range(0, 5) != 0);
            cstrobe_n = ($urandom_range(0, 4) != 0);
            adv_n     = 1'($urandom_range(0, 1));
            cs1_n     = ($urandom_range(0, 9) == 0);
            cs2       = ($urandom_range(0, 9) != 0);
            cs3_n     = ($urandom_range(0, 11) == 0);
            gwr_n     = ($urandom_range(0, 5) != 0);
            bwr_n     = ($urandom_range(0, 2) != 0);
            lane_n    = LN'($urandom);
            addr      = AW'($urandom);
            wdata     = $urandom;
            oe_n      = ($urandom_range(0, 7) == 0);
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule